// File: doc/BRIEF.md
# Grouped Timer/Counter Units with Pin Routing

This block holds a bank of timer/counter units that share a wide array of general-purpose pins. Pins fall into groups by index modulo the unit count. With eight units, unit 3 may claim pin 3, 11, 19 and so on. Each unit can claim at most one pin of its own group at a time. Every pin that no unit claims carries the software-supplied output value and output-enable unchanged.

Each unit keeps three values: a running counter, a period and a threshold. The unit advances on either every clock cycle (fast) or on a shared slow tick that a fixed divider derives from the same clock. A unit runs in one of four modes:

- **Timer:** a periodic interrupt.
- **PWM:** a pulse-width output.
- **One-shot:** a single pulse.
- **Capture:** latches the counter on a rising pin edge.

Each pin also offers a simple edge interrupt.

Software programs a unit through a single-cycle write port that carries a unit number, a register select and a data word.

Top module: `cgpio_timer_bank`

## Requirements
- R1: While reset is applied and in the first cycle after it, every unit interrupt is low, every unit counter reads 0 and no pin is claimed.
- R2: A write with `wr_sel`=3 attaches (data bit 6 = 1) or detaches (bit 6 = 0) the pin whose index is in data bits 5:0. The write takes effect only if that index modulo 8 equals the unit number. Otherwise the write is ignored and the unit keeps its previous pin. A claimed pin shows the unit's output on `gpio_out`.
- R3: A pin not claimed by any unit drives `gpio_out` and `gpio_oe` equal to `sw_out` and `sw_oe` for that pin.
- R4: In timer mode (control bits 1:0 = 0), the counter counts from 0 up to the period and then returns to 0. The interrupt is a one-cycle pulse on each return, so pulses are period+1 ticks apart.
- R5: In PWM mode (control bits 1:0 = 1), the claimed pin is high while the counter is below the threshold. The counter wraps after reaching the period, so the pin is high for threshold ticks out of every period+1.
- R6: In one-shot mode (control bits 1:0 = 2), a control write with the run bit set starts a pulse that is high for max(threshold,1) ticks. The unit then stops with its counter frozen and gives one interrupt pulse as the output falls.
- R7: In capture mode (control bits 1:0 = 3), the claimed pin is an input (`gpio_oe` low). A rising edge on it copies the counter into the threshold and raises a one-cycle interrupt, one clock after the edge is sampled. If the counter wraps in that same cycle, the value captured is the one held before the wrap.
- R8: Control bit 2 set gives one tick per clock cycle. Cleared, it gives one tick every SLOW_DIV cycles from a shared divider. A slow tick is never high two cycles in a row.
- R9: A pin with `pin_irq_en` set raises `pin_irq` for one cycle after a rising edge on `gpio_in`. A pin without it never raises `pin_irq`.
- R10: A control write (`wr_sel`=2; bit 3 = run) clears the counter. A unit that is not running keeps its counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | 3 | Target unit number |
| wr_sel | input | 2 | 0 period, 1 threshold, 2 control, 3 pin select |
| wr_data | input | 16 | Write data |
| gpio_in | input | 64 | Pin input levels |
| sw_out | input | 64 | Software output value for unclaimed pins |
| sw_oe | input | 64 | Software output enable for unclaimed pins |
| pin_irq_en | input | 64 | Per-pin edge interrupt enable |
| gpio_out | output | 64 | Pin output levels |
| gpio_oe | output | 64 | Pin output enables |
| pin_irq | output | 64 | Per-pin rising-edge interrupt pulses |
| unit_irq | output | 8 | Per-unit interrupt pulses |
| unit_cnt | output | 128 | Counters of all units, unit k at bits 16k+15:16k |
| unit_thr | output | 128 | Thresholds of all units, same layout |

## Verification
In capture mode, a rising pin edge and the counter's return to zero can land on the same clock edge. Both then update unit state at once: the threshold takes the captured value and the counter wraps.

The bench provokes this collision by setting a short period and watching the counter output between edges. It raises the pin exactly when the counter reads the period value. After the edge, the threshold must hold the period, the counter must read zero and the interrupt must be high.

// File: rtl/cgt_pkg.sv
package cgt_pkg;

   typedef enum logic [1:0] {
      MD_TIMER   = 2'd0,
      MD_PWM     = 2'd1,
      MD_ONESHOT = 2'd2,
      MD_CAPTURE = 2'd3
   } cgt_mode_e;

   localparam logic [1:0] RS_PERIOD = 2'd0;
   localparam logic [1:0] RS_THRESH = 2'd1;
   localparam logic [1:0] RS_CTRL   = 2'd2;
   localparam logic [1:0] RS_PIN    = 2'd3;

   localparam int CTL_FAST_BIT = 2;
   localparam int CTL_RUN_BIT  = 3;

endpackage

// File: rtl/cgt_tick_div.sv
module cgt_tick_div #(
   parameter int SLOW_DIV = 4,
   localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic slow_tick
);

   generate
      if (SLOW_DIV <= 1) begin : g_nodiv
         assign slow_tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (div_q == DIV_W'(SLOW_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         assign slow_tick = (div_q == DIV_W'(SLOW_DIV - 1));

         AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            slow_tick |=> !slow_tick);  // R8
      end
   endgenerate

endmodule

// File: rtl/cgt_unit.sv
module cgt_unit
   import cgt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PIN_W   = 6,
   parameter int GRP_W   = 3,
   parameter int UNIT_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cap_in,
   output logic             pin_out,
   output logic             pin_drive,
   output logic             pin_attach,
   output logic [PIN_W-1:0] pin_sel,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] thr_o,
   output logic             irq_o
);

   cgt_mode_e        mode_q;
   logic             fast_q;
   logic             run_q;
   logic             cap_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] thr_q;
   logic [CNT_W:0]   cnt_inc;
   logic             tick;
   logic             ctrl_wr;
   logic             grp_ok;
   logic             cap_rise;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign tick     = fast_q | slow_tick;
   assign ctrl_wr  = wr_en && (wr_sel == RS_CTRL);
   assign grp_ok   = (wr_data[GRP_W-1:0] == GRP_W'(UNIT_ID));
   assign cap_rise = cap_in & ~cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= MD_TIMER;
         fast_q     <= 1'b0;
         run_q      <= 1'b0;
         cap_q      <= 1'b0;
         cnt_q      <= '0;
         per_q      <= '0;
         thr_q      <= '0;
         irq_o      <= 1'b0;
         pin_attach <= 1'b0;
         pin_sel    <= PIN_W'(UNIT_ID);
      end else begin
         irq_o <= 1'b0;
         cap_q <= cap_in;
         if (ctrl_wr) begin
            mode_q <= cgt_mode_e'(wr_data[1:0]);
            fast_q <= wr_data[CTL_FAST_BIT];
            run_q  <= wr_data[CTL_RUN_BIT];
            cnt_q  <= '0;
         end else if (run_q) begin
            if (mode_q == MD_CAPTURE && cap_rise) begin
               thr_q <= cnt_q;
               irq_o <= 1'b1;
            end
            if (tick) begin
               if (mode_q == MD_ONESHOT) begin
                  cnt_q <= cnt_inc[CNT_W-1:0];
                  if (cnt_inc >= {1'b0, thr_q}) begin
                     run_q <= 1'b0;
                     irq_o <= 1'b1;
                  end
               end else if (cnt_q >= per_q) begin
                  cnt_q <= '0;
                  if (mode_q == MD_TIMER) irq_o <= 1'b1;
               end else begin
                  cnt_q <= cnt_inc[CNT_W-1:0];
               end
            end
         end
         if (wr_en && wr_sel == RS_PERIOD) per_q <= wr_data;
         if (wr_en && wr_sel == RS_THRESH) thr_q <= wr_data;
         if (wr_en && wr_sel == RS_PIN && grp_ok) begin
            pin_attach <= wr_data[PIN_W];
            pin_sel    <= wr_data[PIN_W-1:0];
         end
      end
   end

   always_comb begin
      unique case (mode_q)
         MD_PWM:     pin_out = run_q && (cnt_q < thr_q);
         MD_ONESHOT: pin_out = run_q;
         default:    pin_out = 1'b0;
      endcase
   end

   assign pin_drive = (mode_q != MD_CAPTURE);
   assign cnt_o     = cnt_q;
   assign thr_o     = thr_q;

   AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && mode_q == MD_TIMER) |-> (cnt_q == '0));  // R4
   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q) && mode_q == MD_ONESHOT && !$past(ctrl_wr)) |-> irq_o);  // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ctrl_wr) |=> $stable(cnt_q));  // R10
   AST_PIN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      pin_attach |-> (pin_sel[GRP_W-1:0] == GRP_W'(UNIT_ID)));  // R2

endmodule

// File: rtl/cgt_pin_matrix.sv
module cgt_pin_matrix #(
   parameter int NUM_PINS = 64,
   parameter int GROUPS   = 8,
   parameter int PIN_W    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       gpio_in,
   input  logic [NUM_PINS-1:0]       sw_out,
   input  logic [NUM_PINS-1:0]       sw_oe,
   input  logic [NUM_PINS-1:0]       pin_irq_en,
   input  logic [GROUPS-1:0]         unit_out,
   input  logic [GROUPS-1:0]         unit_drive,
   input  logic [GROUPS-1:0]         unit_attach,
   input  logic [GROUPS*PIN_W-1:0]   unit_sel,
   output logic [NUM_PINS-1:0]       gpio_out,
   output logic [NUM_PINS-1:0]       gpio_oe,
   output logic [GROUPS-1:0]         cap_in,
   output logic [NUM_PINS-1:0]       pin_irq
);

   logic [NUM_PINS-1:0] in_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int G = p % GROUPS;
      logic owned;
      assign owned       = unit_attach[G] && (unit_sel[G*PIN_W +: PIN_W] == PIN_W'(p));
      assign gpio_out[p] = owned ? unit_out[G]   : sw_out[p];
      assign gpio_oe[p]  = owned ? unit_drive[G] : sw_oe[p];

      AST_PIN_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         pin_irq[p] |=> !pin_irq[p]);  // R9
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      assign cap_in[g] = unit_attach[g] & gpio_in[unit_sel[g*PIN_W +: PIN_W]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q    <= '0;
         pin_irq <= '0;
      end else begin
         in_q    <= gpio_in;
         pin_irq <= pin_irq_en & gpio_in & ~in_q;
      end
   end

endmodule

// File: rtl/cgpio_timer_bank.sv
module cgpio_timer_bank #(
   parameter int GROUPS   = 8,
   parameter int NUM_PINS = 64,
   parameter int CNT_W    = 16,
   parameter int SLOW_DIV = 4,
   localparam int GRP_W   = $clog2(GROUPS),
   localparam int PIN_W   = $clog2(NUM_PINS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [GRP_W-1:0]          wr_unit,
   input  logic [1:0]                wr_sel,
   input  logic [CNT_W-1:0]          wr_data,
   input  logic [NUM_PINS-1:0]       gpio_in,
   input  logic [NUM_PINS-1:0]       sw_out,
   input  logic [NUM_PINS-1:0]       sw_oe,
   input  logic [NUM_PINS-1:0]       pin_irq_en,
   output logic [NUM_PINS-1:0]       gpio_out,
   output logic [NUM_PINS-1:0]       gpio_oe,
   output logic [NUM_PINS-1:0]       pin_irq,
   output logic [GROUPS-1:0]         unit_irq,
   output logic [GROUPS*CNT_W-1:0]   unit_cnt,
   output logic [GROUPS*CNT_W-1:0]   unit_thr
);

   if (GROUPS < 2 || (GROUPS & (GROUPS - 1)) != 0) begin : g_chk_groups
      $error("GROUPS must be a power of two of at least 2");
   end
   if (NUM_PINS != (1 << PIN_W) || NUM_PINS < GROUPS) begin : g_chk_pins
      $error("NUM_PINS must be a power of two not below GROUPS");
   end
   if (CNT_W < PIN_W + 1 || CNT_W < 4) begin : g_chk_cnt
      $error("CNT_W must hold the pin field and the control bits");
   end

   logic                    slow_tick;
   logic [GROUPS-1:0]       u_out;
   logic [GROUPS-1:0]       u_drive;
   logic [GROUPS-1:0]       u_attach;
   logic [GROUPS*PIN_W-1:0] u_sel;
   logic [GROUPS-1:0]       u_cap;

   cgt_tick_div #(.SLOW_DIV(SLOW_DIV)) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_unit
      cgt_unit #(
         .CNT_W   (CNT_W),
         .PIN_W   (PIN_W),
         .GRP_W   (GRP_W),
         .UNIT_ID (g)
      ) i_unit (
         .clk        (clk),
         .rst_n      (rst_n),
         .slow_tick  (slow_tick),
         .wr_en      (wr_en && (wr_unit == GRP_W'(g))),
         .wr_sel     (wr_sel),
         .wr_data    (wr_data),
         .cap_in     (u_cap[g]),
         .pin_out    (u_out[g]),
         .pin_drive  (u_drive[g]),
         .pin_attach (u_attach[g]),
         .pin_sel    (u_sel[g*PIN_W +: PIN_W]),
         .cnt_o      (unit_cnt[g*CNT_W +: CNT_W]),
         .thr_o      (unit_thr[g*CNT_W +: CNT_W]),
         .irq_o      (unit_irq[g])
      );
   end

   cgt_pin_matrix #(
      .NUM_PINS (NUM_PINS),
      .GROUPS   (GROUPS),
      .PIN_W    (PIN_W)
   ) i_matrix (
      .clk         (clk),
      .rst_n       (rst_n),
      .gpio_in     (gpio_in),
      .sw_out      (sw_out),
      .sw_oe       (sw_oe),
      .pin_irq_en  (pin_irq_en),
      .unit_out    (u_out),
      .unit_drive  (u_drive),
      .unit_attach (u_attach),
      .unit_sel    (u_sel),
      .gpio_out    (gpio_out),
      .gpio_oe     (gpio_oe),
      .cap_in      (u_cap),
      .pin_irq     (pin_irq)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> (unit_irq == '0 && u_attach == '0));  // R1

endmodule

// File: tb/test_cgpio_timer_bank.sv
`timescale 1ns/1ps
module test_cgpio_timer_bank;
   localparam int GROUPS = 8, NUM_PINS = 64, CNT_W = 16, SLOW_DIV = 4;
   localparam int NV = 10;
   localparam int VU [NV] = '{0, 1, 2, 3, 4, 5, 7, 6, 2, 2};
   localparam int VI [NV] = '{8, 9, 10, 12, 4, 63, 63, 22, 3, 3};
   localparam int VP [NV] = '{8, 9, 10, 12, 4, 63, 63, 22, 3, 10};
   localparam int VE [NV] = '{1, 1, 1, 0, 1, 0, 1, 1, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_unit = '0;
   logic [1:0] wr_sel = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [NUM_PINS-1:0] gpio_in = '0, sw_out = '0, sw_oe = '0, pin_irq_en = '0;
   logic [NUM_PINS-1:0] gpio_out, gpio_oe, pin_irq;
   logic [GROUPS-1:0] unit_irq;
   logic [GROUPS*CNT_W-1:0] unit_cnt, unit_thr;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   cgpio_timer_bank #(.GROUPS(GROUPS), .NUM_PINS(NUM_PINS), .CNT_W(CNT_W),
                      .SLOW_DIV(SLOW_DIV)) i_cgpio_timer_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit), .wr_sel(wr_sel),
      .wr_data(wr_data), .gpio_in(gpio_in), .sw_out(sw_out), .sw_oe(sw_oe),
      .pin_irq_en(pin_irq_en), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .pin_irq(pin_irq), .unit_irq(unit_irq), .unit_cnt(unit_cnt), .unit_thr(unit_thr));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int u, input int s, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_unit = u[2:0]; wr_sel = s[1:0]; wr_data = d[CNT_W-1:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic int cnt0();
      return int'(unit_cnt[CNT_W-1:0]);
   endfunction

   task automatic irq_gap(input string req, input int exp);
      int n = 0;
      while (!unit_irq[0] && n < 100) begin @(negedge clk); n++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!unit_irq[0] && n < 100);
      chk(req, n, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi, ir, c;
      sw_out = 64'hA5A5_0F0F_3C3C_F00F;
      sw_oe  = 64'h0FF0_1234_8001_7E7E;
      repeat (4) @(negedge clk);
      chk("R1 irq in reset", int'(unit_irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq after reset", int'(unit_irq), 0);
      chk("R1 counters after reset", int'(unit_cnt != '0), 0);
      chk("R3 out passthrough", int'(gpio_out == sw_out), 1);
      chk("R3 oe passthrough", int'(gpio_oe == sw_oe), 1);

      // R2 vector table: PWM units with threshold above period drive a constant 1
      sw_out = '0; sw_oe = '0;
      for (int u = 0; u < GROUPS; u++) begin
         wr(u, 0, 3); wr(u, 1, 15); wr(u, 2, 13);
      end
      for (int v = 0; v < NV; v++) begin
         wr(VU[v], 3, 64 | VI[v]);
         chk("R2 pin claim out", int'(gpio_out[VP[v]]), VE[v]);
         chk("R2 pin claim oe", int'(gpio_oe[VP[v]]), VE[v]);
      end
      sw_out[30] = 1'b1; sw_oe[30] = 1'b1;
      @(negedge clk);
      chk("R3 unclaimed pin", int'({gpio_out[30], gpio_oe[30]}), 3);
      for (int u = 0; u < GROUPS; u++) begin
         wr(u, 3, u); wr(u, 2, 0);
      end
      chk("R2 detach", int'(gpio_out[8]), 0);

      // R10 stopped unit holds a cleared counter
      repeat (10) @(negedge clk);
      chk("R10 stopped counter", cnt0(), 0);

      // R4 timer fast, period 4
      wr(0, 0, 4); wr(0, 2, 12);
      irq_gap("R4 timer irq spacing", 5);
      irq_gap("R4 timer irq spacing again", 5);

      // R8 slow tick, period 1 -> 2 slow ticks per wrap
      wr(0, 0, 1); wr(0, 2, 8);
      irq_gap("R8 slow tick spacing", 2 * SLOW_DIV);

      // R5 PWM period 4, threshold 2
      wr(0, 0, 4); wr(0, 1, 2); wr(0, 3, 64); wr(0, 2, 13);
      hi = 0;
      for (int i = 0; i < 20; i++) begin hi += int'(gpio_out[0]); @(negedge clk); end
      chk("R5 pwm high count", hi, 8);
      chk("R5 pwm drives pin", int'(gpio_oe[0]), 1);

      // R6 one-shot threshold 6
      wr(0, 1, 6); wr(0, 2, 14);
      hi = 0; ir = 0;
      for (int i = 0; i < 20; i++) begin
         hi += int'(gpio_out[0]); ir += int'(unit_irq[0]); @(negedge clk);
      end
      chk("R6 one-shot width", hi, 6);
      chk("R6 one-shot irq count", ir, 1);
      c = cnt0();
      repeat (5) @(negedge clk);
      chk("R6 one-shot stopped", cnt0(), c);
      wr(0, 1, 0); wr(0, 2, 14);
      hi = 0;
      for (int i = 0; i < 10; i++) begin hi += int'(gpio_out[0]); @(negedge clk); end
      chk("R6 zero threshold width", hi, 1);
      wr(0, 2, 6);
      chk("R10 control write clears", cnt0(), 0);

      // R7 capture
      wr(0, 0, 1000); wr(0, 2, 15);
      chk("R7 capture pin input", int'(gpio_oe[0]), 0);
      repeat (3) @(negedge clk);
      c = cnt0();
      gpio_in[0] = 1'b1;
      @(negedge clk);
      chk("R7 captured value", int'(unit_thr[CNT_W-1:0]), c);
      chk("R7 capture irq", int'(unit_irq[0]), 1);
      gpio_in[0] = 1'b0;
      @(negedge clk);
      chk("R7 capture irq pulse", int'(unit_irq[0]), 0);

      // R7 capture edge coinciding with counter wrap
      wr(0, 0, 5); wr(0, 2, 15);
      for (int i = 0; i < 20 && cnt0() != 5; i++) @(negedge clk);
      gpio_in[0] = 1'b1;
      @(negedge clk);
      chk("R7 wrap capture value", int'(unit_thr[CNT_W-1:0]), 5);
      chk("R7 wrap counter", cnt0(), 0);
      chk("R7 wrap irq", int'(unit_irq[0]), 1);
      gpio_in[0] = 1'b0;

      // R9 simple pin interrupts
      pin_irq_en[20] = 1'b1;
      @(negedge clk);
      gpio_in[20] = 1'b1; gpio_in[21] = 1'b1;
      @(negedge clk);
      chk("R9 enabled pin irq", int'(pin_irq[20]), 1);
      chk("R9 disabled pin irq", int'(pin_irq[21]), 0);
      @(negedge clk);
      chk("R9 irq pulse ends", int'(pin_irq[20]), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule